// File: doc/BRIEF.md
# Programmable Binary Divider Timer

This block is a sixteen-stage synchronous binary counter with a four-way tap selector. A two-bit code picks one counter stage as the timing output, so the block divides its clock by 256, 1024, 8192 or 65536. A polarity input decides the idle level of the output: the level shown while reset is held and during the first half of every period. The counter advances on each rising clock edge.

A mode input selects between two behaviours. In recycle mode the chosen stage drives the output all the time, which gives a square wave. In single-cycle mode the output makes one transition, half a period after reset, and a latch then holds it there. Only a reset or a change of the mode level releases the latch. Two sources can reset the block: a master reset input, and a power-on pulse that counts only while its active-low enable pin is low. The reset is applied on the clock edge, and the counter does not count while a reset is present.

The single-cycle control is a four-state machine. ST_HOLD is entered on every reset edge. From ST_HOLD the machine goes to ST_FREE when mode is 1 and to ST_ARMED when mode is 0. A change of the mode level moves ST_FREE to ST_ARMED. A change of the mode level moves ST_ARMED to ST_FREE, and a high tap moves ST_ARMED to ST_FIRED. A change of the mode level moves ST_FIRED to ST_FREE. A mode change is found by comparing mode with its value registered on the previous edge.

Top module: `prog_div_timer`

## Requirements
- R1: Each rising clock edge that sees no reset adds one to the counter, and the counter wraps from 65535 to 0.
- R2: The tap code {sel_a, sel_b} selects the output stage. 00 selects stage 13 (8192 clocks), 01 selects stage 10 (1024), 10 selects stage 8 (256) and 11 selects stage 16 (65536). Stage n is counter bit n-1.
- R3: With mode=1, out equals the selected stage bit XOR polarity_sel. After a release from reset, out holds polarity_sel for 2^(n-1) clocks and then the inverse for 2^(n-1) clocks, and this repeats.
- R4: While any reset is active, out equals polarity_sel in the same cycle.
- R5: With mode=0, out changes to the inverse of polarity_sel when the count reaches 2^(n-1). It then stays at that level, including after the selected stage falls again, until a reset or a mode change.
- R6: A change of the mode level releases the single-cycle latch. After mode returns to 0, out follows the selected stage again until the stage next goes high, and then it latches again.
- R7: master_reset=1 clears the counter on the next edge whatever its state and whatever the level of auto_reset_n.
- R8: por_pulse resets the block only while auto_reset_n=0. When auto_reset_n=1, por_pulse does not change the counter or the output.
- R9: The counter holds at zero for as long as reset is asserted. The first output transition after a release comes exactly 2^(n-1) edges after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| por_pulse | input | 1 | Power-on reset pulse, active high |
| auto_reset_n | input | 1 | 0 lets por_pulse reset the block, 1 blocks it |
| master_reset | input | 1 | Master reset, active high |
| sel_a | input | 1 | Upper bit of the tap code |
| sel_b | input | 1 | Lower bit of the tap code |
| polarity_sel | input | 1 | Idle and reset level of out |
| mode | input | 1 | 1 = recycle, 0 = single cycle |
| out | output | 1 | Timer output |

## Verification
Some properties are checked on every cycle. These are the one-step advance of the counter, the counter clearing on master reset, the reset level of out, the power-on pulse having no effect while its enable is high, and the latch holding in ST_FIRED while mode stays 0. The bench scenarios cover what the per-cycle checks do not. They sweep the tap codes and both polarities and confirm the half-period and full-period edges. They show that the output stays latched across the point where the stage falls, that a pulse on the mode input re-arms the latch, and that a gated power-on pulse leaves the phase unchanged.

// File: rtl/prog_div_pkg.sv
`timescale 1ns/1ps
package prog_div_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_FREE  = 2'd1,
        ST_ARMED = 2'd2,
        ST_FIRED = 2'd3
    } shot_state_e;

    localparam int NUM_TAPS = 4;
    localparam int CODE_W   = $clog2(NUM_TAPS);
endpackage

// File: rtl/div_reset_gen.sv
`timescale 1ns/1ps
module div_reset_gen (
    input  logic por_pulse,
    input  logic auto_reset_n,
    input  logic master_reset,
    output logic rst_any
);
    logic por_gated;

    always_comb begin
        por_gated = por_pulse & ~auto_reset_n;
        rst_any   = master_reset | por_gated;
    end
endmodule

// File: rtl/div_counter.sv
`timescale 1ns/1ps
module div_counter #(
    parameter int STAGES = 16,
    parameter int TAP0   = 13,
    parameter int TAP1   = 10,
    parameter int TAP2   = 8,
    parameter int TAP3   = 16
) (
    input  logic                              clk,
    input  logic                              clr,
    output logic [STAGES-1:0]                 cnt,
    output logic [prog_div_pkg::NUM_TAPS-1:0] taps
);
    localparam int TAP_LIST [prog_div_pkg::NUM_TAPS] = '{TAP0, TAP1, TAP2, TAP3};

    logic [STAGES-1:0] cnt_q;
    logic [STAGES-1:0] carry;

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < STAGES - 1; i++) begin : g_carry
        assign carry[i+1] = carry[i] & cnt_q[i];
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q ^ carry;
        end
    end

    for (genvar t = 0; t < prog_div_pkg::NUM_TAPS; t++) begin : g_tap
        assign taps[t] = cnt_q[TAP_LIST[t]-1];
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/div_tap_mux.sv
`timescale 1ns/1ps
module div_tap_mux (
    input  logic [prog_div_pkg::NUM_TAPS-1:0] taps,
    input  logic [prog_div_pkg::CODE_W-1:0]   code,
    output logic                              tap
);
    always_comb begin
        tap = taps[code];
    end
endmodule

// File: rtl/div_shot_fsm.sv
`timescale 1ns/1ps
module div_shot_fsm
    import prog_div_pkg::*;
(
    input  logic        clk,
    input  logic        rst_any,
    input  logic        mode,
    input  logic        tap,
    input  logic        polarity_sel,
    output logic        out,
    output shot_state_e state
);
    shot_state_e state_q;
    shot_state_e state_d;
    logic        mode_q;
    logic        mode_flip;

    assign mode_flip = mode ^ mode_q;

    always_ff @(posedge clk) begin
        mode_q <= mode;
        if (rst_any) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  state_d = mode ? ST_FREE : ST_ARMED;
            ST_FREE:  if (mode_flip) state_d = ST_ARMED;
            ST_ARMED: begin
                if (mode_flip) begin
                    state_d = ST_FREE;
                end else if (tap) begin
                    state_d = ST_FIRED;
                end
            end
            ST_FIRED: if (mode_flip) state_d = ST_FREE;
            default:  state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        if (rst_any) begin
            out = polarity_sel;
        end else begin
            unique case (state_q)
                ST_FIRED: out = ~polarity_sel;
                ST_HOLD,
                ST_FREE,
                ST_ARMED: out = tap ^ polarity_sel;
                default:  out = polarity_sel;
            endcase
        end
    end

    assign state = state_q;
endmodule

// File: rtl/prog_div_timer.sv
`timescale 1ns/1ps
module prog_div_timer
    import prog_div_pkg::*;
#(
    parameter int STAGES = 16,
    parameter int TAP00  = 13,
    parameter int TAP01  = 10,
    parameter int TAP10  = 8,
    parameter int TAP11  = 16
) (
    input  logic clk,
    input  logic por_pulse,
    input  logic auto_reset_n,
    input  logic master_reset,
    input  logic sel_a,
    input  logic sel_b,
    input  logic polarity_sel,
    input  logic mode,
    output logic out
);
    logic                rst_any;
    logic [STAGES-1:0]   cnt;
    logic [NUM_TAPS-1:0] taps;
    logic                tap;
    shot_state_e         fsm_state;

    div_reset_gen u_rst (
        .por_pulse    (por_pulse),
        .auto_reset_n (auto_reset_n),
        .master_reset (master_reset),
        .rst_any      (rst_any)
    );

    div_counter #(
        .STAGES (STAGES),
        .TAP0   (TAP00),
        .TAP1   (TAP01),
        .TAP2   (TAP10),
        .TAP3   (TAP11)
    ) u_cnt (
        .clk  (clk),
        .clr  (rst_any),
        .cnt  (cnt),
        .taps (taps)
    );

    div_tap_mux u_mux (
        .taps (taps),
        .code ({sel_a, sel_b}),
        .tap  (tap)
    );

    div_shot_fsm u_fsm (
        .clk          (clk),
        .rst_any      (rst_any),
        .mode         (mode),
        .tap          (tap),
        .polarity_sel (polarity_sel),
        .out          (out),
        .state        (fsm_state)
    );
endmodule

// File: rtl/prog_div_timer_chk.sv
`timescale 1ns/1ps
module prog_div_timer_chk
    import prog_div_pkg::*;
#(
    parameter int STAGES = 16
) (
    input logic              clk,
    input logic              master_reset,
    input logic              por_pulse,
    input logic              auto_reset_n,
    input logic              mode,
    input logic              polarity_sel,
    input logic              out,
    input logic              rst_any,
    input logic [STAGES-1:0] cnt,
    input shot_state_e       state
);
    logic seen_rst = 1'b0;

    always_ff @(posedge clk) begin
        if (rst_any) seen_rst <= 1'b1;
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!seen_rst)
        !rst_any |=> (cnt == $past(cnt) + 1'b1)); // R1

    AST_RESET_LEVEL: assert property (@(posedge clk) disable iff (!seen_rst)
        master_reset |-> (out == polarity_sel)); // R4

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!seen_rst)
        (state == ST_FIRED && !mode && !rst_any) |=> (state == ST_FIRED)); // R5

    AST_MASTER_CLEAR: assert property (@(posedge clk) disable iff (!seen_rst)
        master_reset |=> (cnt == '0)); // R7

    AST_POR_IGNORED: assert property (@(posedge clk) disable iff (!seen_rst)
        (por_pulse && auto_reset_n && !master_reset) |=> (cnt == $past(cnt) + 1'b1)); // R8

    AST_HELD_ZERO: assert property (@(posedge clk) disable iff (!seen_rst)
        (rst_any && $past(rst_any)) |-> (cnt == '0)); // R9
endmodule

bind prog_div_timer prog_div_timer_chk #(.STAGES(STAGES)) chk_i (
    .clk          (clk),
    .master_reset (master_reset),
    .por_pulse    (por_pulse),
    .auto_reset_n (auto_reset_n),
    .mode         (mode),
    .polarity_sel (polarity_sel),
    .out          (out),
    .rst_any      (rst_any),
    .cnt          (cnt),
    .state        (fsm_state)
);

// File: tb/prog_div_timer_tb_top.sv
`timescale 1ns/1ps
module prog_div_timer_tb_top;
    logic clk = 1'b0;
    logic por_pulse = 1'b0;
    logic auto_reset_n = 1'b1;
    logic master_reset = 1'b1;
    logic sel_a = 1'b0;
    logic sel_b = 1'b0;
    logic polarity_sel = 1'b0;
    logic mode = 1'b1;
    logic out;

    int checks = 0;
    int fails = 0;
    int k = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prog_div_timer dut_i (
        .clk          (clk),
        .por_pulse    (por_pulse),
        .auto_reset_n (auto_reset_n),
        .master_reset (master_reset),
        .sel_a        (sel_a),
        .sel_b        (sel_b),
        .polarity_sel (polarity_sel),
        .mode         (mode),
        .out          (out)
    );

    function automatic int stage_of(input int code);
        case (code)
            0:       return 13;
            1:       return 10;
            2:       return 8;
            default: return 16;
        endcase
    endfunction

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s at k=%0d: got %b expected %b", req, what, k, got, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic master_pulse();
        @(negedge clk);
        master_reset = 1'b1;
        #0.5;
        check(out, polarity_sel, "R4", "out during master reset");
        repeat (2) @(negedge clk);
        check(out, polarity_sel, "R4", "out while reset held");
        master_reset = 1'b0;
        #0.5;
        check(out, polarity_sel, "R9", "out at release");
        k = 0;
    endtask

    task automatic recycle_sweep(input int code, input logic pol);
        int h;
        h = 1 << (stage_of(code) - 1);
        mode = 1'b1;
        {sel_a, sel_b} = code[1:0];
        polarity_sel = pol;
        master_pulse();
        step(h - 1);
        check(out, pol, "R9", "idle before half period");
        step(1);
        check(out, ~pol, "R2 R3", "first transition at half period");
        step(h - 1);
        check(out, ~pol, "R3", "active level to end of period");
        step(1);
        check(out, pol, "R1 R3", "back to idle at full period");
    endtask

    initial begin
        int mism;
        mism = 0;
        repeat (3) @(negedge clk);
        check(out, 1'b0, "R4", "reset state with polarity 0");
        master_reset = 1'b0;
        k = 0;

        for (int c = 0; c < 3; c++) begin
            for (int p = 0; p < 2; p++) begin
                recycle_sweep(c, p[0]);
            end
        end
        recycle_sweep(3, 1'b0);

        mode = 1'b1;
        {sel_a, sel_b} = 2'b10;
        polarity_sel = 1'b1;
        master_pulse();
        for (int i = 1; i <= 600; i++) begin
            step(1);
            if (out !== (((i >> 7) & 1) == 1 ? 1'b0 : 1'b1)) mism++;
        end
        check(mism == 0, 1'b1, "R3", "cycle-by-cycle square wave");

        polarity_sel = 1'b0;
        auto_reset_n = 1'b1;
        master_pulse();
        step(100);
        por_pulse = 1'b1;
        step(2);
        por_pulse = 1'b0;
        step(25);
        check(out, 1'b0, "R8", "gated por pulse, before half period");
        step(1);
        check(out, 1'b1, "R8", "gated por pulse, phase unchanged");

        auto_reset_n = 1'b0;
        @(negedge clk);
        por_pulse = 1'b1;
        #0.5;
        check(out, 1'b0, "R4 R8", "enabled por forces idle level");
        repeat (2) @(negedge clk);
        por_pulse = 1'b0;
        k = 0;
        step(127);
        check(out, 1'b0, "R8 R9", "restart after por, before half");
        step(1);
        check(out, 1'b1, "R8", "restart after por, at half");

        step(50);
        master_pulse();
        step(127);
        check(out, 1'b0, "R7", "master reset with auto reset enabled");
        step(1);
        check(out, 1'b1, "R7", "timing after master reset");
        auto_reset_n = 1'b1;

        mode = 1'b0;
        polarity_sel = 1'b1;
        {sel_a, sel_b} = 2'b10;
        master_pulse();
        step(127);
        check(out, 1'b1, "R5", "single cycle before half");
        step(1);
        check(out, 1'b0, "R5", "single cycle transition");
        step(128);
        check(out, 1'b0, "R5", "latched past stage fall");
        step(344);
        check(out, 1'b0, "R5", "latched at count 600");
        mode = 1'b1;
        step(1);
        check(out, 1'b1, "R6", "mode raised releases latch");
        mode = 1'b0;
        step(1);
        check(out, 1'b1, "R6", "re-armed follows stage");
        step(37);
        check(out, 1'b1, "R6", "re-armed before next rise");
        step(1);
        check(out, 1'b0, "R6", "re-armed latches again");
        step(128);
        check(out, 1'b0, "R5 R6", "second latch holds");

        polarity_sel = 1'b0;
        {sel_a, sel_b} = 2'b01;
        master_pulse();
        step(511);
        check(out, 1'b0, "R2 R5", "single cycle tap 01 before half");
        step(1);
        check(out, 1'b1, "R2 R5", "single cycle tap 01 transition");
        step(512);
        check(out, 1'b1, "R5", "single cycle tap 01 holds at full period");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired at k=%0d: got hung expected finish", k);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule